// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Pin Overrides

This block is an eight-pin bidirectional I/O port. For each pin, software sets a direction bit and an output bit through a small register bus. Those bits, together with a global pull-up disable, produce the pad's output enable, drive value and pull-up request. The pad input is gated by a per-pin digital-input enable. It then passes through a synchronizer into a read-only pin register.

On-chip peripherals can take pins over through four enable/value override pairs per pin. The pairs cover pull-up, direction, drive value and digital-input enable. An active enable replaces the register-derived value with the peripheral's value. The override terms differ from pin to pin:

- The top two pins can be claimed as oscillator or clock pins.
- Pins 5 to 2 carry the serial-peripheral clock, data and select lines. The role each one takes depends on master or slave mode.
- Two of those pins are shared with the receiver and transmitter of a serial port.
- Three pins carry timer compare outputs.
- Pin 0 has no override and only feeds capture and change-detect logic.

The gated digital input of every pin is also brought out for the peripherals.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset the direction and output registers hold 0, every pad is an input (pad_oe 0), no pull-up is requested and no pad is driven high.
- R2: Register map on `addr`: 0 is the pin register (synchronized input), 1 is the direction register (1 = output), 2 is the output register. Address 3 reads 0. Writes take effect on the clock edge where `wr_en` is high, and `rd_data` is combinational.
- R3: The pin register shows the gated pad input two clock edges after it changes, and a write to address 0 changes no register.
- R4: Without an override on a pin, pad_oe equals its direction bit and pad_out equals its output bit. pad_pu is 1 exactly when the direction bit is 0, the output bit is 1 and `pud_all` is 0. With `pud_all` high, no pin ever requests a pull-up.
- R5: Pin 7 is claimed when `osc_rc_sel`, `osc_ext_sel` or `tosc_en` is high. Pin 6 is claimed when `osc_rc_sel` or `tosc_en` is high. A claimed pin has pull-up and output enable forced to 0, and its bit reads 0 at addresses 0, 1 and 2.
- R6: Pin 5 (serial clock) is forced to input in slave mode (`spi_en` and not `spi_master`), with pull-up = output bit AND NOT `pud_all`. In master mode it drives `spi_sck_out`.
- R7: Pin 4 (master-in/slave-out) is forced to input, with pull-up = output bit AND NOT `pud_all`, in master mode or when `uart_rx_en` is high. In slave mode it drives `spi_miso_out`.
- R8: Pin 3 (master-out/slave-in) is forced to input, with pull-up = output bit AND NOT `pud_all`, in slave mode or when `uart_tx_en` is high. Its drive is overridden in master mode or when `t2_cmpa_en` is high, and the value driven is `spi_mosi_out | t2_cmpa_out | uart_txd`.
- R9: Pin 2 is forced to input in slave mode, with pull-up = output bit AND NOT `pud_all`. Pin 2 drives `t1_cmpb_out` when `t1_cmpb_en` is high, and pin 1 drives `t1_cmpa_out` when `t1_cmpa_en` is high.
- R10: Pin 0 follows its registers regardless of any override control.
- R11: `din` equals `pad_in` gated by the digital-input enable. The enable is 1 on every pin, except that a claimed oscillator pin (R5) has it forced to 0. This holds even when its change mask bit in `pc_mask` and `pc_grp_en` are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| pud_all | input | 1 | Global pull-up disable |
| osc_rc_sel | input | 1 | Internal RC oscillator selected |
| osc_ext_sel | input | 1 | External clock selected |
| tosc_en | input | 1 | Asynchronous timer oscillator enabled |
| spi_en | input | 1 | Serial peripheral enabled |
| spi_master | input | 1 | Serial peripheral in master mode |
| spi_sck_out | input | 1 | Serial clock drive in master mode |
| spi_mosi_out | input | 1 | Master data out |
| spi_miso_out | input | 1 | Slave data out |
| uart_rx_en | input | 1 | Second serial port receiver enabled |
| uart_tx_en | input | 1 | Second serial port transmitter enabled |
| uart_txd | input | 1 | Transmit data |
| t2_cmpa_en | input | 1 | Timer 2 compare A output enabled |
| t2_cmpa_out | input | 1 | Timer 2 compare A output level |
| t1_cmpa_en | input | 1 | Timer 1 compare A output enabled |
| t1_cmpa_out | input | 1 | Timer 1 compare A output level |
| t1_cmpb_en | input | 1 | Timer 1 compare B output enabled |
| t1_cmpb_out | input | 1 | Timer 1 compare B output level |
| pc_grp_en | input | 1 | Pin-change group enable |
| pc_mask | input | 8 | Per-pin change-interrupt mask |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up requests |
| din | output | 8 | Gated digital input to peripherals |

## Verification
The bench targets the places where a pin's role flips with mode:

- **Serial peripheral mode.** Slave mode must release pins 5, 3 and 2 and keep pin 4 driven, while master mode must release only pin 4. A design with the mode term inverted would drive into an external master's clock.
- **Pull-up value under override.** A design that took the pull-up from the default formula would lose the pull-up on a pin whose direction bit is 1.
- **Shared pin 3 drive.** The value driven is an OR of three sources and is overridden in two cases, so missing a source would leave the pin stuck when the compare output alone is enabled.
- **Oscillator pins.** They must read back 0 and disable their input buffer even with change detection enabled. A design that let the change-enable override win would feed oscillator swing into the synchronizer.
- **Pin register.** Its two-edge latency and its immunity to writes are probed directly.

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       pud_all,
  input  logic       osc_rc_sel,
  input  logic       osc_ext_sel,
  input  logic       tosc_en,
  input  logic       spi_en,
  input  logic       spi_master,
  input  logic       spi_sck_out,
  input  logic       spi_mosi_out,
  input  logic       spi_miso_out,
  input  logic       uart_rx_en,
  input  logic       uart_tx_en,
  input  logic       uart_txd,
  input  logic       t2_cmpa_en,
  input  logic       t2_cmpa_out,
  input  logic       t1_cmpa_en,
  input  logic       t1_cmpa_out,
  input  logic       t1_cmpb_en,
  input  logic       t1_cmpb_out,
  input  logic       pc_grp_en,
  input  logic [7:0] pc_mask,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_pu,
  output logic [7:0] din
);

  localparam logic [1:0] A_PIN = 2'd0;
  localparam logic [1:0] A_DIR = 2'd1;
  localparam logic [1:0] A_OUT = 2'd2;

  logic [7:0] dir_q, port_q;
  logic [SYNC_STAGES-1:0][7:0] sync_q;

  wire spi_slv = spi_en & ~spi_master;
  wire spi_mst = spi_en & spi_master;
  wire osc6    = osc_rc_sel | tosc_en;
  wire osc7    = osc6 | osc_ext_sel;

  // override enables and values, one bit per pin
  wire [7:0] ov_pu_en  = {osc7, osc6, spi_slv, spi_mst | uart_rx_en,
                          spi_slv | uart_tx_en, spi_slv, 2'b00};
  wire [7:0] ov_pu_val = {2'b00, port_q[5:2] & {4{~pud_all}}, 2'b00};
  wire [7:0] ov_dir_en  = ov_pu_en;
  wire [7:0] ov_dir_val = 8'h00;
  wire [7:0] ov_drv_en  = {2'b00, spi_mst, spi_slv, spi_mst | t2_cmpa_en,
                           t1_cmpb_en, t1_cmpa_en, 1'b0};
  wire [7:0] ov_drv_val = {2'b00, spi_sck_out, spi_miso_out,
                           spi_mosi_out | t2_cmpa_out | uart_txd,
                           t1_cmpb_out, t1_cmpa_out, 1'b0};
  wire [7:0] ov_die_en  = (pc_mask & {8{pc_grp_en}}) | {osc7, osc6, 6'b0};
  wire [7:0] ov_die_val = {~osc7, ~osc6, 6'h3f};

  wire [7:0] pu_def  = ~dir_q & port_q & {8{~pud_all}};
  wire [7:0] die_eff = (ov_die_en & ov_die_val) | ~ov_die_en;
  wire [7:0] keep    = {~osc7, ~osc6, 6'h3f};

  assign pad_pu  = (ov_pu_en  & ov_pu_val)  | (~ov_pu_en  & pu_def);
  assign pad_oe  = (ov_dir_en & ov_dir_val) | (~ov_dir_en & dir_q);
  assign pad_out = (ov_drv_en & ov_drv_val) | (~ov_drv_en & port_q);
  assign din     = pad_in & die_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      port_q <= '0;
    end else if (wr_en) begin
      if (addr == A_DIR) dir_q  <= wr_data;
      if (addr == A_OUT) port_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  always_comb begin
    case (addr)
      A_PIN:   rd_data = sync_q[SYNC_STAGES-1] & keep;
      A_DIR:   rd_data = dir_q & keep;
      A_OUT:   rd_data = port_q & keep;
      default: rd_data = 8'h00;
    endcase
  end

endmodule

module gpio_altfn_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       pud_all,
  input logic       osc_rc_sel,
  input logic       tosc_en,
  input logic       spi_en,
  input logic       spi_master,
  input logic [7:0] pad_oe,
  input logic [7:0] pad_pu,
  input logic [7:0] din,
  input logic [7:0] dir_q,
  input logic [7:0] port_q
);
  AST_OSC_TOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_rc_sel || tosc_en) |-> (pad_oe[7:6] == 2'b00 && pad_pu[7:6] == 2'b00)); // R5
  AST_SCK_SLAVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> !pad_oe[5]); // R6
  AST_MISO_MASTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> !pad_oe[4]); // R7
  AST_PIN0_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> pad_oe[0] == $past(wr_data[0])); // R10
  AST_PIN_REG_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> ($stable(dir_q) && $stable(port_q))); // R3
  AST_PULLUP_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pud_all |-> pad_pu == 8'h00); // R4
  AST_OSC_INPUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rc_sel |-> din[7:6] == 2'b00); // R11
endmodule

bind gpio_altfn_port gpio_altfn_port_chk u_chk (.*);

// File: tb/gpio_altfn_port_bench.sv
module gpio_altfn_port_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic pud_all = 0, osc_rc_sel = 0, osc_ext_sel = 0, tosc_en = 0;
  logic spi_en = 0, spi_master = 0, spi_sck_out = 0, spi_mosi_out = 0, spi_miso_out = 0;
  logic uart_rx_en = 0, uart_tx_en = 0, uart_txd = 0;
  logic t2_cmpa_en = 0, t2_cmpa_out = 0, t1_cmpa_en = 0, t1_cmpa_out = 0;
  logic t1_cmpb_en = 0, t1_cmpb_out = 0, pc_grp_en = 0;
  logic [7:0] pc_mask = 0, pad_in = 0, pad_out, pad_oe, pad_pu, din;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_altfn_port u_gpio_altfn_port (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rd_data;
  endtask

  task automatic clear_ctl();
    pud_all = 0; osc_rc_sel = 0; osc_ext_sel = 0; tosc_en = 0;
    spi_en = 0; spi_master = 0; spi_sck_out = 0; spi_mosi_out = 0; spi_miso_out = 0;
    uart_rx_en = 0; uart_tx_en = 0; uart_txd = 0;
    t2_cmpa_en = 0; t2_cmpa_out = 0; t1_cmpa_en = 0; t1_cmpa_out = 0;
    t1_cmpb_en = 0; t1_cmpb_out = 0; pc_grp_en = 0; pc_mask = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 out", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd1, 8'h0F); wr(2'd2, 8'hA5);
    rd(2'd1, v); chk("R2 dir readback", v, 8'h0F);
    rd(2'd2, v); chk("R2 out readback", v, 8'hA5);
    rd(2'd3, v); chk("R2 addr3 zero", v, 8'h00);
    chk("R4 pad_oe", pad_oe, 8'h0F);
    chk("R4 pad_out", pad_out, 8'hA5);
    chk("R4 pad_pu", pad_pu, 8'hA0);
    pud_all = 1; #1;
    chk("R4 pud_all", pad_pu, 8'h00);
    pud_all = 0;
  endtask

  task automatic t_sync();
    logic [7:0] v;
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); rd(2'd0, v); chk("R3 one edge", v, 8'h00);
    @(negedge clk); rd(2'd0, v); chk("R3 two edges", v, 8'h3C);
    wr(2'd0, 8'hFF);
    rd(2'd1, v); chk("R3 ro dir", v, 8'h0F);
    rd(2'd2, v); chk("R3 ro out", v, 8'hA5);
    rd(2'd0, v); chk("R3 ro pin", v, 8'h3C);
  endtask

  task automatic t_osc();
    logic [7:0] v;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    @(negedge clk); pad_in = 8'hFF; osc_rc_sel = 1; pc_grp_en = 1; pc_mask = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R5 oe rc", pad_oe, 8'h3F);
    chk("R5 pu rc", pad_pu, 8'h00);
    rd(2'd1, v); chk("R5 dir read", v, 8'h3F);
    rd(2'd2, v); chk("R5 out read", v, 8'h3F);
    rd(2'd0, v); chk("R5 pin read", v, 8'h3F);
    chk("R11 din osc", din, 8'h3F);
    osc_rc_sel = 0; osc_ext_sel = 1; #1;
    chk("R5 ext only pin7", pad_oe, 8'h7F);
    osc_ext_sel = 0; #1;
    chk("R11 din pc only", din, 8'hFF);
    clear_ctl();
  endtask

  task automatic t_spi_slave();
    spi_en = 1; spi_master = 0; spi_miso_out = 0; #1;
    chk("R6 slave oe", pad_oe, 8'hD3);
    chk("R6 slave pu", pad_pu, 8'h2C);
    chk("R7 slave miso drive", pad_out, 8'hEF);
    spi_miso_out = 1; #1;
    chk("R7 slave miso high", pad_out, 8'hFF);
    pud_all = 1; #1;
    chk("R9 slave pu gated", pad_pu, 8'h00);
    clear_ctl();
  endtask

  task automatic t_spi_master();
    spi_en = 1; spi_master = 1; #1;
    chk("R7 master oe", pad_oe, 8'hEF);
    chk("R7 master pu", pad_pu, 8'h10);
    chk("R6 master drive", pad_out, 8'hD7);
    spi_sck_out = 1; spi_mosi_out = 1; #1;
    chk("R8 master drive high", pad_out, 8'hFF);
    clear_ctl();
  endtask

  task automatic t_uart_timer();
    wr(2'd2, 8'h00);
    uart_rx_en = 1; uart_tx_en = 1; #1;
    chk("R7 R8 uart oe", pad_oe, 8'hE7);
    uart_txd = 1; #1;
    chk("R8 txd no enable", pad_out, 8'h00);
    t2_cmpa_en = 1; #1;
    chk("R8 txd via cmp", pad_out, 8'h08);
    uart_txd = 0; t2_cmpa_out = 1; #1;
    chk("R8 t2 cmp", pad_out, 8'h08);
    clear_ctl();
    t1_cmpa_en = 1; t1_cmpa_out = 1; #1;
    chk("R9 t1 a", pad_out, 8'h02);
    t1_cmpb_en = 1; t1_cmpb_out = 1; #1;
    chk("R9 t1 b", pad_out, 8'h06);
    t1_cmpa_en = 0; t1_cmpb_en = 0; #1;
    chk("R9 t1 disabled", pad_out, 8'h00);
    clear_ctl();
  endtask

  task automatic t_pin0();
    wr(2'd1, 8'h01); wr(2'd2, 8'h01);
    spi_en = 1; spi_master = 1; uart_rx_en = 1; uart_tx_en = 1;
    t2_cmpa_en = 1; t1_cmpa_en = 1; t1_cmpb_en = 1; pud_all = 1; #1;
    chk("R10 pin0 oe", {7'b0, pad_oe[0]}, 8'h01);
    chk("R10 pin0 out", {7'b0, pad_out[0]}, 8'h01);
    clear_ctl();
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual hung expected done");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_sync();
    t_osc();
    t_spi_slave();
    t_spi_master();
    t_uart_timer();
    t_pin0();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule